// File: doc/BRIEF.md
# PCI Configuration Access Bridge

This block sits on the host side of a PCI hierarchy and implements the classic two-port configuration mechanism. Software writes a 32-bit selector into an address register. It then moves bytes, words or dwords through a four-byte data window. The selector holds an enable flag, a bus number, a device/function number and a dword register index. The bridge decodes these fields and routes each window access to the configuration space of one of a parameterized number of device slots. Each slot holds 256 bytes.

Each slot exposes six base address registers, and the size and kind of each one is fixed by parameters. A dword write to a present BAR is stored already aligned to the region size, with the kind code ORed into the low bits. Writing all ones therefore reads back as a sizing mask. A write of any value other than zero or all ones also emits a one-cycle map event. The event carries the slot, the BAR index and the new base address, and the block that owns the I/O or memory decoders uses it to move the region.

Top module: `cfg_bridge`

## Requirements
- R1: A dword write to port 0xCF8 loads the 32-bit address register, and a dword read of 0xCF8 returns it. The register is 0 after reset. Accesses of other sizes to 0xCF8 neither change it nor return it; such a read returns 0.
- R2: The data window covers ports 0xCFC to 0xCFF, and the low two port bits select the starting byte lane. req_size encodes 0 = byte, 1 = word, 2 = dword; code 3 is invalid. A byte access is legal at any lane, a word access at lanes 0 to 2, and a dword access only at lane 0. An illegal window access is ignored on write and returns 0 on read. Read data is right-aligned and zero-extended.
- R3: When bit 31 of the address register is 0, or bits 1:0 of it are not 00, window writes change nothing and window reads return 0.
- R4: The bus is taken from address bits 23:16 and the device/function from bits 15:8. Slot k answers only at bus SLOT_BUS (default 0) and device/function 8*k. Any other target reads as 0 and ignores writes.
- R5: The configuration byte offset is address bits 7:2 followed by the port's low two bits. An ordinary write changes exactly the bytes covered by its size and lane.
- R6: A dword write to a present BAR (offsets 0x10 to 0x27, BAR n at 0x10+4n) stores (value AND NOT(size-1)) OR kind code. The kind code is 1 for I/O, 0 for memory and 8 for prefetchable memory.
- R7: A BAR write of a value other than 0 and 0xFFFFFFFF drives map_valid high for exactly the cycle after the request, with map_slot, map_bar and map_base. map_base is the value with bits 1:0 cleared for I/O, or bits 3:0 cleared for memory.
- R8: Writing 0 or 0xFFFFFFFF to a BAR raises no map event. After an all-ones write, a read of that BAR returns the size mask ORed with the kind code.
- R9: A BAR whose size is zero, and any byte or word write in the BAR range, is stored as ordinary bytes with no map event.
- R10: Every read request gives exactly one rsp_valid pulse two cycles after it is accepted. Writes give no response.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 16 | I/O port address of the access |
| req_size | input | 2 | 0 byte, 1 word, 2 dword |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data, right-aligned, zero-extended |
| map_valid | output | 1 | One-cycle BAR remap event |
| map_slot | output | SLOT_W | Slot whose BAR moved |
| map_bar | output | 3 | BAR index 0 to 5 |
| map_base | output | 32 | New region base address |

## Verification
The checker assumes that req_valid stays low while reset is asserted, because the response-timing property looks two cycles into the past. It also assumes that req_size and req_port are held for the whole cycle in which req_valid is high. The map properties trace each event back to a dword write at the data port while the enable bit is set. The stimulus drives every request for a single cycle between falling edges and never overlaps one read with the next. Random traffic includes invalid size codes, disabled selectors, unpopulated slots and the two non-mapping BAR values, so that the assertions see those paths.

// File: rtl/cfgb_pkg.sv
`timescale 1ns/1ps
package cfgb_pkg;

  typedef enum logic [1:0] {
    ACC_BYTE  = 2'd0,
    ACC_WORD  = 2'd1,
    ACC_DWORD = 2'd2,
    ACC_RSVD  = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    BK_MEM     = 2'd0,
    BK_IO      = 2'd1,
    BK_PFMEM   = 2'd2,
    BK_MEM_ALT = 2'd3
  } bar_kind_e;

  localparam int BARS_PER_SLOT = 6;
  localparam int BAR_LG_W      = 5;
  localparam int BAR_KIND_W    = 2;
  localparam int CFG_WORDS     = 64;
  localparam logic [5:0] BAR_WORD_FIRST = 6'd4;
  localparam logic [5:0] BAR_WORD_LAST  = 6'd9;

  // Low-bit code stored in a BAR for each region kind.
  function automatic logic [31:0] kind_code(input logic [1:0] k);
    case (k)
      BK_IO:    kind_code = 32'h0000_0001;
      BK_PFMEM: kind_code = 32'h0000_0008;
      default:  kind_code = 32'h0000_0000;
    endcase
  endfunction

  // Byte lanes touched by an access; all-zero marks an illegal shape.
  function automatic logic [3:0] lane_enables(input logic [1:0] sz, input logic [1:0] off);
    case (sz)
      ACC_BYTE:  lane_enables = 4'b0001 << off;
      ACC_WORD:  lane_enables = (off == 2'd3) ? 4'b0000 : (4'b0011 << off);
      ACC_DWORD: lane_enables = (off == 2'd0) ? 4'b1111 : 4'b0000;
      default:   lane_enables = 4'b0000;
    endcase
  endfunction

  function automatic logic [31:0] size_mask(input logic [BAR_LG_W-1:0] lg);
    size_mask = ~((32'd1 << lg) - 32'd1);
  endfunction

  function automatic logic [31:0] lane_extract(input logic [31:0] w, input logic [1:0] off,
                                               input logic [1:0] sz);
    logic [31:0] s;
    s = w >> {off, 3'b000};
    case (sz)
      ACC_BYTE: lane_extract = {24'h0, s[7:0]};
      ACC_WORD: lane_extract = {16'h0, s[15:0]};
      default:  lane_extract = s;
    endcase
  endfunction

endpackage

// File: rtl/cfgb_decode.sv
`timescale 1ns/1ps
module cfgb_decode import cfgb_pkg::*; #(
  parameter int          NUM_SLOTS = 2,
  parameter int          SLOT_W    = 1,
  parameter logic [7:0]  SLOT_BUS  = 8'h00,
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input  logic [15:0]       port,
  input  logic [1:0]        size,
  input  logic [31:0]       cfg_addr,
  output logic              addr_hit,
  output logic              win_hit,
  output logic [SLOT_W-1:0] slot,
  output logic [5:0]        word_idx,
  output logic [3:0]        byte_en,
  output logic [1:0]        lane,
  output logic              bar_hit,
  output logic [2:0]        bar_idx
);

  logic       port_in_win;
  logic       shape_ok;
  logic       enabled;
  logic       dev_hit;
  logic [7:0] bus_f;
  logic [7:0] devfn_f;
  logic       unused_addr_hi;

  assign unused_addr_hi = ^cfg_addr[30:24];

  always_comb begin
    bus_f       = cfg_addr[23:16];
    devfn_f     = cfg_addr[15:8];
    addr_hit    = (port == ADDR_PORT) && (size == ACC_DWORD);
    port_in_win = (port[15:2] == DATA_PORT[15:2]);
    byte_en     = lane_enables(size, port[1:0]);
    shape_ok    = |byte_en;
    enabled     = cfg_addr[31] && (cfg_addr[1:0] == 2'b00);
    dev_hit     = (bus_f == SLOT_BUS) && (devfn_f[2:0] == 3'd0)
                  && (int'(devfn_f[7:3]) < NUM_SLOTS);
    win_hit     = port_in_win && shape_ok && enabled && dev_hit;
    slot        = devfn_f[3 +: SLOT_W];
    word_idx    = cfg_addr[7:2];
    lane        = port[1:0];
    bar_hit     = win_hit && (size == ACC_DWORD)
                  && (word_idx >= BAR_WORD_FIRST) && (word_idx <= BAR_WORD_LAST);
    bar_idx     = 3'(word_idx - BAR_WORD_FIRST);
  end

endmodule

// File: rtl/cfgb_bar_unit.sv
`timescale 1ns/1ps
module cfgb_bar_unit import cfgb_pkg::*; #(
  parameter int NUM_SLOTS = 2,
  parameter int SLOT_W    = 1,
  parameter logic [NUM_SLOTS*BARS_PER_SLOT*BAR_LG_W-1:0]   BAR_LG2  = '0,
  parameter logic [NUM_SLOTS*BARS_PER_SLOT*BAR_KIND_W-1:0] BAR_KIND = '0
) (
  input  logic [SLOT_W-1:0] slot,
  input  logic [2:0]        bar_idx,
  input  logic [31:0]       wdata,
  output logic              present,
  output logic [31:0]       store_val,
  output logic              map_req,
  output logic [31:0]       map_base
);

  localparam int N_BARS = NUM_SLOTS * BARS_PER_SLOT;

  logic [BAR_LG_W-1:0]   lg;
  logic [BAR_KIND_W-1:0] kind;

  always_comb begin
    lg   = '0;
    kind = '0;
    for (int j = 0; j < N_BARS; j++) begin
      if (j == int'(slot) * BARS_PER_SLOT + int'(bar_idx)) begin
        lg   = BAR_LG2[j*BAR_LG_W +: BAR_LG_W];
        kind = BAR_KIND[j*BAR_KIND_W +: BAR_KIND_W];
      end
    end
    present   = (lg != '0);
    store_val = (wdata & size_mask(lg)) | kind_code(kind);
    map_req   = present && (wdata != 32'h0) && (wdata != 32'hFFFF_FFFF);
    map_base  = (kind == BK_IO) ? {wdata[31:2], 2'b00} : {wdata[31:4], 4'b0000};
  end

endmodule

// File: rtl/cfgb_cfg_ram.sv
`timescale 1ns/1ps
module cfgb_cfg_ram #(
  parameter int DEPTH = 128,
  parameter int AW    = 7
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [3:0]    be,
  input  logic [AW-1:0] addr,
  input  logic [31:0]   wdata,
  output logic [31:0]   rdata
);

  for (genvar b = 0; b < 4; b++) begin : g_lane
    logic [7:0] mem [DEPTH];
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (en) begin
        if (we && be[b]) mem[addr] <= wdata[8*b +: 8];
        q <= mem[addr];
      end
    end
    assign rdata[8*b +: 8] = q;
  end

endmodule

// File: rtl/cfg_bridge.sv
`timescale 1ns/1ps
module cfg_bridge import cfgb_pkg::*; #(
  parameter int          NUM_SLOTS = 2,
  parameter logic [7:0]  SLOT_BUS  = 8'h00,
  parameter logic [15:0] ADDR_PORT = 16'hCF8,
  parameter logic [15:0] DATA_PORT = 16'hCFC,
  // log2 of each BAR size, 0 = absent; entry slot*6+bar
  parameter logic [NUM_SLOTS*BARS_PER_SLOT*BAR_LG_W-1:0] BAR_LG2 = {
    5'd0, 5'd0, 5'd0, 5'd0, 5'd0, 5'd8,
    5'd0, 5'd0, 5'd20, 5'd12, 5'd2, 5'd3},
  // kind of each BAR: 0 memory, 1 I/O, 2 prefetchable memory
  parameter logic [NUM_SLOTS*BARS_PER_SLOT*BAR_KIND_W-1:0] BAR_KIND = {
    2'd0, 2'd0, 2'd0, 2'd0, 2'd0, 2'd1,
    2'd0, 2'd0, 2'd2, 2'd0, 2'd1, 2'd1},
  localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [15:0]       req_port,
  input  logic [1:0]        req_size,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              map_valid,
  output logic [SLOT_W-1:0] map_slot,
  output logic [2:0]        map_bar,
  output logic [31:0]       map_base
);

  localparam int RAM_AW    = SLOT_W + 6;
  localparam int RAM_DEPTH = NUM_SLOTS * CFG_WORDS;

  logic [31:0]       cfg_addr_q;
  logic              addr_hit, win_hit, bar_hit;
  logic [SLOT_W-1:0] slot;
  logic [5:0]        word_idx;
  logic [3:0]        byte_en;
  logic [1:0]        lane;
  logic [2:0]        bar_idx;

  cfgb_decode #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .SLOT_BUS(SLOT_BUS),
    .ADDR_PORT(ADDR_PORT), .DATA_PORT(DATA_PORT)
  ) u_dec (
    .port(req_port), .size(req_size), .cfg_addr(cfg_addr_q),
    .addr_hit(addr_hit), .win_hit(win_hit), .slot(slot), .word_idx(word_idx),
    .byte_en(byte_en), .lane(lane), .bar_hit(bar_hit), .bar_idx(bar_idx)
  );

  logic        bar_present, bar_map_req;
  logic [31:0] bar_store, bar_base;

  cfgb_bar_unit #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W), .BAR_LG2(BAR_LG2), .BAR_KIND(BAR_KIND)
  ) u_bar (
    .slot(slot), .bar_idx(bar_idx), .wdata(req_wdata), .present(bar_present),
    .store_val(bar_store), .map_req(bar_map_req), .map_base(bar_base)
  );

  logic              wr_req, rd_req, bar_wr, ram_en;
  logic [3:0]        ram_be;
  logic [31:0]       ram_wdata, ram_q;
  logic [RAM_AW-1:0] ram_addr;

  always_comb begin
    wr_req    = req_valid && req_write;
    rd_req    = req_valid && !req_write;
    bar_wr    = wr_req && bar_hit && bar_present;
    ram_en    = req_valid && win_hit;
    ram_be    = bar_wr ? 4'hF : byte_en;
    ram_wdata = bar_wr ? bar_store : (req_wdata << {lane, 3'b000});
    ram_addr  = {slot, word_idx};
  end

  cfgb_cfg_ram #(.DEPTH(RAM_DEPTH), .AW(RAM_AW)) u_ram (
    .clk(clk), .en(ram_en), .we(wr_req), .be(ram_be), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_q)
  );

  always_ff @(posedge clk) begin
    if (rst) cfg_addr_q <= '0;
    else if (wr_req && addr_hit) cfg_addr_q <= req_wdata;
  end

  // Read pipeline stage 1: RAM access in flight, side information held.
  logic        s1_rd, s1_addr_rd, s1_win_rd;
  logic [1:0]  s1_lane, s1_size;
  logic [31:0] s1_addr_snap;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_rd        <= 1'b0;
      s1_addr_rd   <= 1'b0;
      s1_win_rd    <= 1'b0;
      s1_lane      <= '0;
      s1_size      <= '0;
      s1_addr_snap <= '0;
    end else begin
      s1_rd        <= rd_req;
      s1_addr_rd   <= rd_req && addr_hit;
      s1_win_rd    <= rd_req && win_hit;
      s1_lane      <= lane;
      s1_size      <= req_size;
      s1_addr_snap <= cfg_addr_q;
    end
  end

  // Stage 2: lane alignment and registered response.
  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= s1_rd;
      if (s1_addr_rd)     rsp_rdata <= s1_addr_snap;
      else if (s1_win_rd) rsp_rdata <= lane_extract(ram_q, s1_lane, s1_size);
      else                rsp_rdata <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      map_valid <= 1'b0;
      map_slot  <= '0;
      map_bar   <= '0;
      map_base  <= '0;
    end else begin
      map_valid <= bar_wr && bar_map_req;
      if (bar_wr && bar_map_req) begin
        map_slot <= slot;
        map_bar  <= bar_idx;
        map_base <= bar_base;
      end
    end
  end

endmodule

// File: rtl/cfgb_checker.sv
`timescale 1ns/1ps
module cfgb_checker #(
  parameter logic [15:0] DATA_PORT = 16'hCFC
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_write,
  input logic [15:0] req_port,
  input logic [1:0]  req_size,
  input logic [31:0] req_wdata,
  input logic        rsp_valid,
  input logic [31:0] rsp_rdata,
  input logic        map_valid,
  input logic [31:0] map_base,
  input logic [31:0] cfg_addr_q
);

  p_read_response_r10: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(req_valid && !req_write, 2));

  p_write_silent_r10: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write) |-> ##2 !rsp_valid);

  p_byte_zero_ext_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && $past(req_size, 2) == 2'd0) |-> (rsp_rdata[31:8] == 24'h0));

  p_map_enabled_r3: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> $past(cfg_addr_q[31] && cfg_addr_q[1:0] == 2'b00));

  p_map_source_r7: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> $past(req_valid && req_write && req_size == 2'd2 && req_port == DATA_PORT));

  p_map_aligned_r7: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> (map_base[1:0] == 2'b00));

  p_map_not_extreme_r8: assert property (@(posedge clk) disable iff (rst)
    map_valid |-> ($past(req_wdata) != 32'h0 && $past(req_wdata) != 32'hFFFF_FFFF));

endmodule

bind cfg_bridge cfgb_checker #(.DATA_PORT(DATA_PORT)) u_cfgb_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_port(req_port), .req_size(req_size), .req_wdata(req_wdata),
  .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .map_valid(map_valid),
  .map_base(map_base), .cfg_addr_q(cfg_addr_q)
);

// File: tb/test_cfg_bridge.sv
`timescale 1ns/1ps
module test_cfg_bridge;

  localparam int NS = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_port = '0;
  logic [1:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        map_valid;
  logic [0:0]  map_slot;
  logic [2:0]  map_bar;
  logic [31:0] map_base;

  always #2.5 clk = ~clk;

  cfg_bridge i_cfg_bridge (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_port(req_port), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .map_valid(map_valid),
    .map_slot(map_slot), .map_bar(map_bar), .map_base(map_base)
  );

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  logic [7:0]  mdl_mem [NS*256];
  logic [31:0] mdl_addr = 32'h0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int bar_lg(int s, int b);
    if (s == 0) begin
      case (b)
        0: return 3;
        1: return 2;
        2: return 12;
        3: return 20;
        default: return 0;
      endcase
    end
    if (s == 1 && b == 0) return 8;
    return 0;
  endfunction

  function automatic logic [31:0] bar_type(int s, int b);
    if (s == 0 && (b == 0 || b == 1)) return 32'h1;
    if (s == 0 && b == 3) return 32'h8;
    if (s == 1 && b == 0) return 32'h1;
    return 32'h0;
  endfunction

  function automatic bit mdl_win(input logic [15:0] port, input logic [1:0] size,
                                 output int slot, output int offb, output int nb);
    int off;
    slot = 0; offb = 0;
    nb = (size == 2'd0) ? 1 : (size == 2'd1) ? 2 : (size == 2'd2) ? 4 : 0;
    off = int'(port[1:0]);
    if (port[15:2] != 14'h33F) return 0;
    if (nb == 0 || off + nb > 4) return 0;
    if (!mdl_addr[31] || mdl_addr[1:0] != 2'b00) return 0;
    if (mdl_addr[23:16] != 8'h00 || mdl_addr[10:8] != 3'd0) return 0;
    if (int'(mdl_addr[15:11]) >= NS) return 0;
    slot = int'(mdl_addr[15:11]);
    offb = int'(mdl_addr[7:2]) * 4 + off;
    return 1;
  endfunction

  function automatic logic [31:0] mdl_read(input logic [15:0] port, input logic [1:0] size);
    int slot, offb, nb;
    logic [31:0] v;
    if (port == 16'hCF8 && size == 2'd2) return mdl_addr;
    if (!mdl_win(port, size, slot, offb, nb)) return 32'h0;
    v = 32'h0;
    for (int i = 0; i < nb; i++) v[8*i +: 8] = mdl_mem[slot*256 + offb + i];
    return v;
  endfunction

  task automatic do_write(logic [15:0] port, logic [1:0] size, logic [31:0] data, string req);
    int slot, offb, nb, w, b, lg;
    bit exp_map;
    logic [31:0] exp_base, stored, m;
    exp_map = 1'b0; exp_base = 32'h0; b = 0; slot = 0;
    if (port == 16'hCF8 && size == 2'd2) begin
      mdl_addr = data;
    end else if (mdl_win(port, size, slot, offb, nb)) begin
      w = offb / 4;
      b = w - 4;
      lg = (nb == 4 && w >= 4 && w <= 9) ? bar_lg(slot, b) : 0;
      if (lg != 0) begin
        m = 32'(~((64'd1 << lg) - 64'd1));
        stored = (data & m) | bar_type(slot, b);
        for (int i = 0; i < 4; i++) mdl_mem[slot*256 + w*4 + i] = stored[8*i +: 8];
        if (data != 32'h0 && data != 32'hFFFF_FFFF) begin
          exp_map = 1'b1;
          exp_base = (bar_type(slot, b) == 32'h1) ? (data & ~32'h3) : (data & ~32'hF);
        end
      end else begin
        for (int i = 0; i < nb; i++) mdl_mem[slot*256 + offb + i] = data[8*i +: 8];
      end
    end
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_port = port; req_size = size; req_wdata = data;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    chk(req, 32'(map_valid), 32'(exp_map));
    if (exp_map) begin
      chk(req, 32'(map_slot), 32'(slot));
      chk(req, 32'(map_bar), 32'(b));
      chk(req, map_base, exp_base);
    end
    chk("R10", 32'(rsp_valid), 32'h0);
  endtask

  task automatic do_read(logic [15:0] port, logic [1:0] size, string req);
    logic [31:0] exp;
    exp = mdl_read(port, size);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_port = port; req_size = size;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R10", 32'(rsp_valid), 32'h0);
    @(negedge clk);
    chk("R10", 32'(rsp_valid), 32'h1);
    chk(req, rsp_rdata, exp);
  endtask

  function automatic logic [31:0] sel(int slot, int word);
    return 32'h8000_0000 | (32'(slot) << 11) | (32'(word) << 2);
  endfunction

  task automatic set_addr(logic [31:0] v);
    do_write(16'hCF8, 2'd2, v, "R1");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL R10 watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] seed_v;
    seed_v = $urandom(32'd20417);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1", 32'(rsp_valid), 32'h0);
    chk("R1", 32'(map_valid), 32'h0);
    do_read(16'hCF8, 2'd2, "R1");

    // Fill every configuration byte with byte writes (plain storage).
    for (int s = 0; s < NS; s++) begin
      for (int w = 0; w < 64; w++) begin
        set_addr(sel(s, w));
        for (int b = 0; b < 4; b++)
          do_write(16'hCFC + 16'(b), 2'd0, 32'($urandom % 256), "R5");
      end
    end

    // Directed corner cases.
    set_addr(sel(0, 4));
    do_read(16'hCF8, 2'd2, "R1");
    do_read(16'hCF8, 2'd0, "R1");
    do_write(16'hCFC, 2'd2, 32'h0000_C0F3, "R7");
    do_read(16'hCFC, 2'd2, "R6");
    set_addr(sel(0, 7));
    do_write(16'hCFC, 2'd2, 32'hFFFF_FFFF, "R8");
    do_read(16'hCFC, 2'd2, "R8");
    set_addr(sel(0, 6));
    do_write(16'hCFC, 2'd2, 32'h0, "R8");
    do_read(16'hCFC, 2'd2, "R8");
    do_write(16'hCFC, 2'd2, 32'hF000_1234, "R7");
    do_read(16'hCFC, 2'd2, "R6");
    do_write(16'hCFD, 2'd0, 32'h0000_00AB, "R9");
    do_read(16'hCFC, 2'd2, "R9");
    set_addr(sel(0, 8));
    do_write(16'hCFC, 2'd2, 32'h1234_5678, "R9");
    do_read(16'hCFC, 2'd2, "R9");
    set_addr(sel(1, 4));
    do_write(16'hCFC, 2'd2, 32'h0000_E123, "R7");
    do_read(16'hCFC, 2'd2, "R6");
    set_addr(sel(0, 0) & 32'h7FFF_FFFF);
    do_write(16'hCFC, 2'd2, 32'hDEAD_BEEF, "R3");
    do_read(16'hCFC, 2'd2, "R3");
    set_addr(sel(0, 0));
    do_read(16'hCFC, 2'd2, "R3");
    set_addr(sel(0, 0) | 32'h1);
    do_read(16'hCFC, 2'd2, "R3");
    set_addr(sel(2, 0));
    do_read(16'hCFC, 2'd2, "R4");
    set_addr(sel(0, 0) | 32'h0000_0100);
    do_read(16'hCFC, 2'd2, "R4");
    set_addr(sel(0, 0) | 32'h0001_0000);
    do_write(16'hCFC, 2'd2, 32'h0BAD_F00D, "R4");
    do_read(16'hCFC, 2'd2, "R4");
    set_addr(sel(0, 1));
    do_write(16'hCFF, 2'd1, 32'h0000_5555, "R2");
    do_read(16'hCFE, 2'd1, "R2");
    do_read(16'hCFD, 2'd2, "R2");
    do_read(16'hCFF, 2'd0, "R2");
    do_write(16'hCFE, 2'd1, 32'h0000_1234, "R5");
    do_read(16'hCFC, 2'd2, "R5");

    // Constrained random traffic.
    for (int it = 0; it < 500; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 3) begin
        logic [31:0] a;
        int w;
        w = ($urandom % 2 == 0) ? int'(4 + $urandom % 6) : int'($urandom % 64);
        a = sel(int'($urandom % 3), w);
        if ($urandom % 8 == 0) a[31] = 1'b0;
        if ($urandom % 8 == 0) a[1:0] = 2'($urandom % 3 + 1);
        if ($urandom % 16 == 0) a[16] = 1'b1;
        if ($urandom % 16 == 0) a[8] = 1'b1;
        set_addr(a);
      end else if (op < 7) begin
        logic [31:0] d;
        int dk;
        dk = int'($urandom % 8);
        d = (dk == 0) ? 32'h0 : (dk == 1) ? 32'hFFFF_FFFF : $urandom;
        if ($urandom % 10 == 0) do_write(16'hCF8, 2'($urandom % 4), d, "R1");
        else do_write(16'hCFC + 16'($urandom % 4), 2'($urandom % 4), d, "R6");
      end else begin
        int pk;
        pk = int'($urandom % 8);
        if (pk == 0) do_read(16'hCF8, 2'($urandom % 4), "R1");
        else if (pk == 1) do_read(16'h0080, 2'd2, "R2");
        else do_read(16'hCFC + 16'($urandom % 4), 2'($urandom % 4), "R5");
      end
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule